// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral that sits on a plain single-cycle register port. It has four registers, chosen by a two-bit word index: a data register, a write-one-to-set register, a write-one-to-clear register and a direction register. It keeps an output latch and a direction latch, and it drives one output value and one output enable for each pin. Pin levels come in through a two-flop synchroniser and can be read back through the data register.

Three build-time options shape the block. The first sets what a direction bit means: 1 selects output, 1 selects input, or the block has no direction register at all. The second reverses the pin numbering, so that pin n sits at register bit WIDTH-1-n. The third swaps the bytes of every register word at the bus, giving big-endian byte order. The register width can be 8, 16, 32 or 64 bits, and the number of pins equals that width.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: While reset is held, and when it is released, the output latch is all zeros. In both directional modes every pin is an input, so `pin_oe` is 0, and `rdata` is 0.
- R2: A write to word index 0 (data) loads the output latch with the written word, and `pin_out` shows it after the write edge. The latch and the direction do not change in any cycle that has no write.
- R3: A write to word index 1 (set) drives to 1 every latch bit whose written bit is 1. All other latch bits keep their value.
- R4: A write to word index 2 (clear) drives to 0 every latch bit whose written bit is 1. All other latch bits keep their value.
- R5: With DIR_MODE=1, a direction bit (word index 3) of 1 makes that pin an output (`pin_oe`=1) and a bit of 0 makes it an input.
- R6: With DIR_MODE=2, a direction bit of 1 makes that pin an input and a bit of 0 makes it an output. After reset the direction register reads as all ones.
- R7: With DIR_MODE=0 there is no direction register. `pin_oe` is all ones at all times, writes to index 3 have no effect, index 3 reads as 0, and the data register returns the synchronised pin levels for every bit.
- R8: In both directional modes, a data read returns the latch bit for output pins and the synchronised pin level for input pins. A pin change made before clock edge E1 is seen by a read strobed at edge E3, but not by one strobed at E2.
- R9: A read of the set or clear register returns the current output latch.
- R10: With BIT_REV=1, pin n maps to register bit WIDTH-1-n, for writes and reads alike.
- R11: With BYTE_SWAP=1 (16- or 32-bit width only), register bytes appear on the bus in reversed order. Combined with BIT_REV=1, bit 8b+k of the bus maps to pin 8b+7-k.
- R12: `rdata` is registered: it updates on the edge where `rd_en` is high and holds its value in every cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_sel | input | 2 | Register word index: 0 data, 1 set, 2 clear, 3 direction |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | WIDTH | Write word |
| rdata | output | WIDTH | Read word, valid the cycle after `rd_en` |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Per-pin output enable |

## Verification
A write changes `pin_out` and `pin_oe` on its own edge. A read result appears in `rdata` on the edge where the strobe is sampled. A pin change reaches the read path two edges later. The bench drives every strobe at the falling edge and samples 1 ns after the rising edge that consumes it. For the synchroniser, it changes a pin at a falling edge, lets one rising edge pass, and then strobes reads on the next two edges, expecting the old level and then the new one. Three instances cover the three direction modes. One of them has both bit reversal and byte swap enabled, and its expected bus words are worked out by hand.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_DIR  = 2'd3
  } gpio_reg_e;

  localparam int DIR_NONE = 0;
  localparam int DIR_OUT  = 1;
  localparam int DIR_IN   = 2;

endpackage

// File: rtl/gpio_lane_map.sv
// Static rewiring between bus bit order and pin order. The map is its own
// inverse, so the same module serves the write path and the read path.
module gpio_lane_map #(
  parameter int WIDTH     = 32,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  localparam int NBYTES = WIDTH / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int SRC_B = (BYTE_SWAP ^ BIT_REV) ? (NBYTES - 1 - b) : b;
    for (genvar k = 0; k < 8; k++) begin : g_bit
      localparam int SRC_K = BIT_REV ? (7 - k) : k;
      assign d_o[8*b+k] = d_i[8*SRC_B+SRC_K];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
// Output latch and direction latch, both kept in pin order.
module gpio_out_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int DIR_MODE = DIR_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_reg_e        wr_sel,
  input  logic [WIDTH-1:0] wd_pin,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] oe_q
);
  logic [WIDTH-1:0] out_d;
  logic             out_en;

  always_comb begin
    out_en = wr_en && (wr_sel != REG_DIR);
    out_d  = out_q;
    unique case (wr_sel)
      REG_DATA: out_d = wd_pin;
      REG_SET:  out_d = out_q | wd_pin;
      REG_CLR:  out_d = out_q & ~wd_pin;
      default:  out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  if (DIR_MODE == DIR_NONE) begin : g_no_dir
    assign oe_q = '1;
  end else begin : g_dir
    logic [WIDTH-1:0] oe_d;
    logic             oe_en;
    logic [WIDTH-1:0] oe_r;

    always_comb begin
      oe_en = wr_en && (wr_sel == REG_DIR);
      oe_d  = (DIR_MODE == DIR_IN) ? ~wd_pin : wd_pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     oe_r <= '0;
      else if (oe_en) oe_r <= oe_d;
    end

    assign oe_q = oe_r;

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == REG_DIR) |=> $stable(oe_q)); // R5
  end

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_DATA) |=> out_q == $past(wd_pin)); // R2
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_SET) |=>
      ((out_q & $past(wd_pin)) == $past(wd_pin)) &&
      (((out_q ^ $past(out_q)) & ~$past(wd_pin)) == '0)); // R3
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == REG_CLR) |=>
      ((out_q & $past(wd_pin)) == '0) &&
      (((out_q ^ $past(out_q)) & ~$past(wd_pin)) == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_q)); // R2
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int DIR_MODE  = DIR_OUT,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  localparam bit WIDTH_OK = (WIDTH == 8) || (WIDTH == 16) || (WIDTH == 32) || (WIDTH == 64);
  localparam bit SWAP_OK  = !(BYTE_SWAP && (WIDTH == 64 || WIDTH == 8));

  initial begin
    assert (WIDTH_OK && SWAP_OK && DIR_MODE >= DIR_NONE && DIR_MODE <= DIR_IN)
      else $error("gpio_mmio_ctrl: unsupported parameter combination");
  end

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  gpio_reg_e        sel;
  logic [WIDTH-1:0] wd_pin;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] oe_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] rd_pin;
  logic [WIDTH-1:0] rd_bus;
  logic [WIDTH-1:0] latch_view;
  logic [WIDTH-1:0] dir_view;

  assign sel = gpio_reg_e'(reg_sel);

  gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) i_wr_map (
    .d_i (wdata),
    .d_o (wd_pin)
  );

  gpio_out_regs #(.WIDTH(WIDTH), .DIR_MODE(DIR_MODE)) i_out_regs (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .wr_en  (wr_en),
    .wr_sel (sel),
    .wd_pin (wd_pin),
    .out_q  (out_q),
    .oe_q   (oe_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(2)) i_in_sync (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .pin_i (pin_in),
    .pin_o (pin_sync)
  );

  // Per-pin source for the data read: latch where the pin drives.
  if (DIR_MODE == DIR_NONE) begin : g_view_none
    assign latch_view = '0;
    assign dir_view   = '0;
  end else if (DIR_MODE == DIR_IN) begin : g_view_in
    assign latch_view = oe_q;
    assign dir_view   = ~oe_q;
  end else begin : g_view_out
    assign latch_view = oe_q;
    assign dir_view   = oe_q;
  end

  always_comb begin
    unique case (sel)
      REG_DATA: rd_pin = (out_q & latch_view) | (pin_sync & ~latch_view);
      REG_SET:  rd_pin = out_q;
      REG_CLR:  rd_pin = out_q;
      default:  rd_pin = dir_view;
    endcase
  end

  gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) i_rd_map (
    .d_i (rd_pin),
    .d_o (rd_bus)
  );

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q)  rdata <= '0;
    else if (rd_en) rdata <= rd_bus;
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !rd_en |=> $stable(rdata)); // R12
  AST_SETCLR_READ: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (rd_en && (sel == REG_SET || sel == REG_CLR) && !wr_en) |=>
      (rdata == $past(rd_bus)) && $stable(pin_out)); // R9
endmodule

// File: tb/test_gpio_mmio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_mmio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] rdata_a, pout_a, poe_a;
  logic [15:0] rdata_b, pout_b, poe_b;
  logic [7:0]  rdata_c, pout_c, poe_c;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // A: 32 bit, 1 = output. B: 16 bit, 1 = input, reversed, swapped. C: 8 bit, no direction.
  gpio_mmio_ctrl #(.WIDTH(32), .DIR_MODE(1), .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) i_gpio_mmio_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata_a), .pin_in(pins), .pin_out(pout_a), .pin_oe(poe_a));
  gpio_mmio_ctrl #(.WIDTH(16), .DIR_MODE(2), .BIT_REV(1'b1), .BYTE_SWAP(1'b1)) i_gpio_mmio_ctrl_b (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata[15:0]), .rdata(rdata_b), .pin_in(pins[15:0]), .pin_out(pout_b), .pin_oe(poe_b));
  gpio_mmio_ctrl #(.WIDTH(8), .DIR_MODE(0), .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) i_gpio_mmio_ctrl_c (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata[7:0]), .rdata(rdata_c), .pin_in(pins[7:0]), .pin_out(pout_c), .pin_oe(poe_c));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] s);
    @(negedge clk);
    reg_sel = s; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // Table for instance A. Pins held at A5A5_0F0F.
  typedef struct packed {
    logic        is_rd;
    logic [1:0]  sel;
    logic [31:0] wd;
    logic [31:0] exp_v;   // rdata on reads, pin_out on writes
    logic [31:0] exp_oe;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{1'b0, 2'd3, 32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_0000, 4'd5},
    '{1'b0, 2'd0, 32'h1234_5678, 32'h1234_5678, 32'hFFFF_0000, 4'd2},
    '{1'b1, 2'd0, 32'h0,         32'h1234_0F0F, 32'hFFFF_0000, 4'd8},
    '{1'b0, 2'd1, 32'h0000_00F0, 32'h1234_56F8, 32'hFFFF_0000, 4'd3},
    '{1'b1, 2'd1, 32'h0,         32'h1234_56F8, 32'hFFFF_0000, 4'd9},
    '{1'b0, 2'd2, 32'h1030_0008, 32'h0204_56F0, 32'hFFFF_0000, 4'd4},
    '{1'b1, 2'd2, 32'h0,         32'h0204_56F0, 32'hFFFF_0000, 4'd9},
    '{1'b1, 2'd0, 32'h0,         32'h0204_0F0F, 32'hFFFF_0000, 4'd8},
    '{1'b1, 2'd3, 32'h0,         32'hFFFF_0000, 32'hFFFF_0000, 4'd5}
  };

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 A pin_out in reset", pout_a, 32'h0);
    check("R1 A pin_oe in reset", poe_a, 32'h0);
    check("R1 B pin_oe in reset", {16'h0, poe_b}, 32'h0);
    check("R7 C pin_oe in reset", {24'h0, poe_c}, 32'hFF);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 A rdata after reset", rdata_a, 32'h0);
    check("R1 A pin_oe after reset", poe_a, 32'h0);
    do_read(2'd3);
    check("R1 A dir reads 0", rdata_a, 32'h0);
    check("R6 B dir reads all ones", {16'h0, rdata_b}, 32'h0000_FFFF);
    check("R7 C dir reads 0", {24'h0, rdata_c}, 32'h0);

    @(negedge clk); pins = 32'hA5A5_0F0F;
    repeat (3) @(posedge clk);

    for (int i = 0; i < 9; i++) begin
      if (TBL[i].is_rd) begin
        do_read(TBL[i].sel);
        check($sformatf("R%0d table %0d rdata", TBL[i].req, i), rdata_a, TBL[i].exp_v);
      end else begin
        do_write(TBL[i].sel, TBL[i].wd);
        check($sformatf("R%0d table %0d pin_out", TBL[i].req, i), pout_a,
              (TBL[i].sel == 2'd3) ? pout_a : TBL[i].exp_v);
      end
      check($sformatf("R%0d table %0d pin_oe", TBL[i].req, i), poe_a, TBL[i].exp_oe);
    end

    // R8: synchroniser latency on input pin 0 of A.
    @(negedge clk); pins = 32'hA5A5_0F0E;
    do_read(2'd0);
    check("R8 read at second edge sees old level", rdata_a, 32'h0204_0F0F);
    do_read(2'd0);
    check("R8 read at third edge sees new level", rdata_a, 32'h0204_0F0E);

    // R12: rdata holds without a strobe.
    repeat (3) @(posedge clk);
    #1;
    check("R12 rdata holds", rdata_a, 32'h0204_0F0E);

    // R6 R10 R11: instance B, reversed bits and swapped bytes.
    do_write(2'd3, 32'h0000_0000);
    check("R6 B dir 0 means output", {16'h0, poe_b}, 32'h0000_FFFF);
    do_write(2'd0, 32'h0000_0180);
    check("R10 R11 B data maps to pins", {16'h0, pout_b}, 32'h0000_8001);
    do_write(2'd3, 32'h0000_00F0);
    check("R6 B dir 1 means input", {16'h0, poe_b}, 32'h0000_FFF0);
    do_read(2'd3);
    check("R11 B dir read back", {16'h0, rdata_b}, 32'h0000_00F0);
    do_read(2'd0);
    check("R8 R11 B mixed data read", {16'h0, rdata_b}, 32'h0000_0170);
    do_write(2'd1, 32'h0000_0002);
    check("R3 R10 B set bit", {16'h0, pout_b}, 32'h0000_8041);
    do_read(2'd1);
    check("R9 R11 B set read", {16'h0, rdata_b}, 32'h0000_0182);

    // R7: instance C, no direction register.
    do_write(2'd0, 32'h0000_003C);
    check("R7 C pin_out", {24'h0, pout_c}, 32'h3C);
    do_read(2'd0);
    check("R7 C data reads pins", {24'h0, rdata_c}, 32'h0E);
    do_write(2'd3, 32'h0000_0055);
    check("R7 C dir write ignored", {24'h0, poe_c}, 32'hFF);
    do_read(2'd3);
    check("R7 C dir reads 0", {24'h0, rdata_c}, 32'h0);
    check("R2 C latch unchanged by dir write", {24'h0, pout_c}, 32'h3C);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule